// File: doc/BRIEF.md
# Byte-Addressable Load/Store Unit

This unit serves the data-memory side of a 32-bit register-to-register processor. Each request supplies a base register value, a signed 16-bit displacement, a two-bit operation code and a store operand. The unit adds the displacement to the base, checks word alignment and then reads or writes an internal byte-organised memory. Loaded values come back one clock later as a full 32-bit register result.

Byte loads fill the upper 24 bits of the result with copies of the fetched byte's top bit. Byte stores write only the operand's lowest byte. Word accesses cover four consecutive bytes in big-endian order. A word request whose effective address is not a multiple of four is refused: it touches no memory and raises a one-cycle fault pulse. The internal array is enabled by a select strobe and steered by a write strobe. The control half of the design drives both strobes.

Top module: `lsu_top`

## Requirements
- R1: The effective address is `baseVal` plus the sign-extended `offsetImm`, and only its low 10 bits select a byte of the 1024-byte memory. Higher bits wrap away.
- R2: `reqOp` is encoded as 2'b00 load byte, 2'b01 load word, 2'b10 store byte and 2'b11 store word. Bit 1 marks a store and bit 0 marks a word access.
- R3: A byte store writes `storeData[7:0]` to the single addressed byte and leaves every other byte unchanged.
- R4: A byte load returns the addressed byte in bits 7:0, with bit 7 copied into bits 31:8.
- R5: Word accesses are big-endian. The byte at the effective address holds bits 31:24, and the byte at the effective address plus 3 holds bits 7:0.
- R6: A word request whose effective address has bits 1:0 not equal to 2'b00 sets `alignFault` for exactly the following cycle. A faulting store leaves memory unchanged. A faulting load returns `loadValid` high with `loadData` zero. Byte requests never fault.
- R7: `loadValid` is high exactly in the cycle after an accepted load request. `loadData` is zero whenever `loadValid` is low.
- R8: While `reqValid` is low, the other request inputs are ignored. Memory is not written, and the outputs stay zero in the next cycle.
- R9: During and just after reset, `loadValid`, `alignFault` and `loadData` are zero.
- R10: A load issued in the cycle right after a store sees the stored bytes. A store issued in the cycle right after a load does not alter the value that load returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | Operation code (see R2) |
| baseVal | input | 32 | Base register value |
| offsetImm | input | 16 | Signed displacement |
| storeData | input | 32 | Source register value for stores |
| loadData | output | 32 | Load result, registered |
| loadValid | output | 1 | Load result present |
| alignFault | output | 1 | Misaligned word request seen in the previous cycle |

## Verification
Two events can share a clock edge: the read of a load and the write of a store that follows it at once, or the write of a store and the read of the load behind it. The bench issues same-address store/load and load/store pairs on consecutive cycles. It judges each pair against a byte-array model that applies a store only after the preceding load's value has been captured. Misaligned stores are then read back to confirm nothing moved. A long mix of random requests is compared with the model on every clock.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    OP_LDB = 2'b00,
    OP_LDW = 2'b01,
    OP_STB = 2'b10,
    OP_STW = 2'b11
  } lsuOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic memSel;    // array enabled this cycle
    logic memWrite;  // write (1) or read (0) when selected
    logic wordAcc;   // four-lane access
    logic loadReq;   // a load was accepted
    logic fault;     // misaligned word request
  } lsuStrobe_t;

endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic [1:0]                    reqOp,
  input  logic [$clog2(WORD_BYTES)-1:0] addrLow,
  output lsuStrobe_t                    strobe,
  output logic                          loadValid,
  output logic                          alignFault
);

  logic isWord;
  logic isStore;
  logic misaligned;

  always_comb begin
    isWord          = reqOp[0];
    isStore         = reqOp[1];
    misaligned      = isWord && (addrLow != '0);
    strobe.fault    = reqValid && misaligned;
    strobe.memSel   = reqValid && !misaligned;
    strobe.memWrite = reqValid && !misaligned && isStore;
    strobe.wordAcc  = isWord;
    strobe.loadReq  = reqValid && !isStore;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loadValid  <= 1'b0;
      alignFault <= 1'b0;
    end else begin
      loadValid  <= strobe.loadReq;
      alignFault <= strobe.fault;
    end
  end

  // R6: a byte request never produces a fault pulse
  a_r6_byte_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqOp[0]) |=> !alignFault);

endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 16,
  parameter int MEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offsetImm,
  input  logic [DATA_W-1:0] storeData,
  input  lsuStrobe_t        strobe,
  output logic [$clog2(DATA_W/8)-1:0] addrLow,
  output logic [DATA_W-1:0] loadData
);

  localparam int LANES   = DATA_W / 8;
  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int LANE_W  = $clog2(LANES);

  logic [DATA_W-1:0] effFull;
  logic [ADDR_W-1:0] effAddr;
  logic [7:0]        memArr [MEM_BYTES];
  logic [ADDR_W-1:0] laneAddr [LANES];
  logic [7:0]        rdByte   [LANES];
  logic [7:0]        wrByte   [LANES];
  logic [LANES-1:0]  laneWe;
  logic [DATA_W-1:0] wordRd;
  logic [DATA_W-1:0] loadNext;

  always_comb begin
    effFull = baseVal + {{(DATA_W-OFF_W){offsetImm[OFF_W-1]}}, offsetImm};
    effAddr = effFull[ADDR_W-1:0];
    addrLow = effFull[LANE_W-1:0];
  end

  // Lane g holds the byte at effAddr+g; lane 0 is most significant in a word
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_comb begin
      laneAddr[g] = effAddr + ADDR_W'(g);
      rdByte[g]   = memArr[laneAddr[g]];
      laneWe[g]   = strobe.memWrite && (strobe.wordAcc || (g == 0));
      wrByte[g]   = strobe.wordAcc ? storeData[DATA_W-1-8*g -: 8] : storeData[7:0];
      wordRd[DATA_W-1-8*g -: 8] = rdByte[g];
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES; g++) begin
      if (laneWe[g]) memArr[laneAddr[g]] <= wrByte[g];
    end
  end

  always_comb begin
    loadNext = '0;
    if (strobe.memSel && !strobe.memWrite) begin
      if (strobe.wordAcc) loadNext = wordRd;
      else                loadNext = {{(DATA_W-8){rdByte[0][7]}}, rdByte[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) loadData <= '0;
    else        loadData <= loadNext;
  end

  // R4: a byte read yields a sign-extended result next cycle
  a_r4_byte_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.memSel && !strobe.memWrite && !strobe.wordAcc)
      |=> (loadData[DATA_W-1:8] == {(DATA_W-8){loadData[7]}}));

  // R6: a refused access never writes
  a_r6_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fault |-> (laneWe == '0));

endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 16,
  parameter int MEM_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offsetImm,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid,
  output logic              alignFault
);

  localparam int LANE_W = $clog2(DATA_W / 8);

  lsuStrobe_t        strobe;
  logic [LANE_W-1:0] addrLow;

  lsu_ctrl #(.WORD_BYTES(DATA_W / 8)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .addrLow    (addrLow),
    .strobe     (strobe),
    .loadValid  (loadValid),
    .alignFault (alignFault)
  );

  lsu_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W), .MEM_BYTES(MEM_BYTES)) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .baseVal   (baseVal),
    .offsetImm (offsetImm),
    .storeData (storeData),
    .strobe    (strobe),
    .addrLow   (addrLow),
    .loadData  (loadData)
  );

  // R7: a valid result follows a load request by one cycle
  a_r7_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    loadValid |-> $past(reqValid && !reqOp[1]));

  // R7: outputs quiet when no result
  a_r7_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !loadValid |-> (loadData == '0));

  // R6: a faulting load returns zero
  a_r6_fault_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (alignFault && loadValid) |-> (loadData == '0));

  // R6: a fault is caused by a word request only
  a_r6_fault_from_word: assert property (@(posedge clk) disable iff (!rst_n)
    alignFault |-> $past(reqValid && reqOp[0]));

endmodule

// File: tb/tb_lsu_top.sv
module tb_lsu_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'b00;
  logic [31:0] baseVal = '0;
  logic [15:0] offsetImm = '0;
  logic [31:0] storeData = '0;
  logic [31:0] loadData;
  logic        loadValid;
  logic        alignFault;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [1024];

  lsu_top dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .baseVal(baseVal), .offsetImm(offsetImm), .storeData(storeData),
    .loadData(loadData), .loadValid(loadValid), .alignFault(alignFault)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkOut(input logic [31:0] eData, input logic eValid,
                          input logic eFault, input string tag);
    checks++;
    if (loadData !== eData || loadValid !== eValid || alignFault !== eFault) begin
      errors++;
      $display("FAIL %s: data=%h valid=%b fault=%b expected data=%h valid=%b fault=%b",
               tag, loadData, loadValid, alignFault, eData, eValid, eFault);
    end
  endtask

  // Drive one request at a falling edge, check its outcome at the next one
  task automatic doOp(input logic v, input logic [1:0] op, input logic [31:0] base,
                      input logic [15:0] off, input logic [31:0] sd, input string tag);
    logic [31:0] ea;
    int a;
    logic [31:0] eData;
    logic eValid, eFault;
    ea = base + {{16{off[15]}}, off};
    a = int'(ea % 1024);
    eData = '0; eValid = 1'b0; eFault = 1'b0;
    reqValid = v; reqOp = op; baseVal = base; offsetImm = off; storeData = sd;
    if (v) begin
      case (op)
        2'b00: begin
          eValid = 1'b1;
          eData = {{24{model[a][7]}}, model[a]};
        end
        2'b01: begin
          eValid = 1'b1;
          if (ea[1:0] != 2'b00) eFault = 1'b1;
          else eData = {model[a], model[a+1], model[a+2], model[a+3]};
        end
        2'b10: model[a] = sd[7:0];
        default: begin
          if (ea[1:0] != 2'b00) eFault = 1'b1;
          else begin
            model[a] = sd[31:24]; model[a+1] = sd[23:16];
            model[a+2] = sd[15:8]; model[a+3] = sd[7:0];
          end
        end
      endcase
    end
    @(negedge clk);
    checkOut(eData, eValid, eFault, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut(32'h0, 1'b0, 1'b0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    checkOut(32'h0, 1'b0, 1'b0, "R9");

    // Fill memory byte by byte (R3)
    for (int i = 0; i < 1024; i++)
      doOp(1'b1, 2'b10, 32'(i), 16'h0, 32'(((i * 7 + 3) & 255) | 32'hABCD_0000), "R3");

    // R4: negative and positive bytes
    doOp(1'b1, 2'b00, 32'd20, 16'h0, 32'h0, "R4");
    doOp(1'b1, 2'b00, 32'd5, 16'h0, 32'h0, "R4");
    // R5: big-endian word read and write
    doOp(1'b1, 2'b01, 32'd8, 16'h0, 32'h0, "R5");
    doOp(1'b1, 2'b11, 32'h100, 16'h4, 32'hA1B2_C3D4, "R5");
    doOp(1'b1, 2'b00, 32'h104, 16'h0, 32'h0, "R5");
    doOp(1'b1, 2'b00, 32'h107, 16'h0, 32'h0, "R5");
    // R10: store then load, load then store, same address
    doOp(1'b1, 2'b11, 32'h140, 16'h0, 32'h5566_7788, "R10");
    doOp(1'b1, 2'b01, 32'h140, 16'h0, 32'h0, "R10");
    doOp(1'b1, 2'b11, 32'h140, 16'h0, 32'h1122_3344, "R10");
    doOp(1'b1, 2'b01, 32'h140, 16'h0, 32'h0, "R10");
    // R3: byte store leaves neighbours
    doOp(1'b1, 2'b10, 32'h200, 16'h1, 32'hFFFF_FF5A, "R3");
    doOp(1'b1, 2'b01, 32'h200, 16'h0, 32'h0, "R3");
    // R1: negative offset and wrap
    doOp(1'b1, 2'b01, 32'h210, 16'hFFFC, 32'h0, "R1");
    doOp(1'b1, 2'b00, 32'hFFFF_FFFE, 16'h3, 32'h0, "R1");
    doOp(1'b1, 2'b00, 32'd1030, 16'h0, 32'h0, "R1");
    doOp(1'b1, 2'b01, 32'h0, 16'h8000, 32'h0, "R1");
    // R6: misaligned word load and store, byte at odd address
    doOp(1'b1, 2'b01, 32'h101, 16'h0, 32'h0, "R6");
    doOp(1'b1, 2'b11, 32'h106, 16'h0, 32'hDEAD_BEEF, "R6");
    doOp(1'b1, 2'b01, 32'h104, 16'h0, 32'h0, "R6");
    doOp(1'b1, 2'b01, 32'h108, 16'h0, 32'h0, "R6");
    doOp(1'b1, 2'b00, 32'h103, 16'h0, 32'h0, "R6");
    // R8: idle request with store op
    doOp(1'b0, 2'b11, 32'h104, 16'h0, 32'h0BAD_F00D, "R8");
    doOp(1'b0, 2'b00, 32'h104, 16'h0, 32'h0, "R8");
    doOp(1'b1, 2'b01, 32'h104, 16'h0, 32'h0, "R8");
    // R7: valid drops after a store
    doOp(1'b1, 2'b10, 32'h30, 16'h0, 32'h77, "R7");

    // R2: random mix
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] op;
      logic [15:0] off;
      logic [9:0] tgt;
      logic [31:0] base;
      op = 2'($urandom);
      off = 16'($urandom);
      tgt = 10'($urandom);
      if (op[0] && ($urandom % 4 != 0)) tgt[1:0] = 2'b00;
      base = (($urandom << 10) | 32'(tgt)) - {{16{off[15]}}, off};
      doOp(($urandom % 8) != 0, op, base, off, $urandom, "R2");
    end

    reqValid = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule